// File: doc/BRIEF.md
# NAND Copy-Back Page Mover with Byte Patching

This block is a host-side sequencer for an 8-bit NAND flash bus. It moves one page inside the device without passing the page through the host. First it reads a source page into the device's internal cache register. Next it overwrites selected bytes of that cached copy and points the copy at a destination row. Last it commits the copy with a program command. The requester supplies the source row and the destination row with a one-cycle start pulse. Byte patches come from a first-word-fall-through FIFO, and each FIFO entry holds one column and one data byte. A single done pulse ends every request, and an error flag is valid with that pulse.

Patches are grouped into runs. When the next FIFO entry's column is exactly one above the previous column, the byte is streamed into the open data phase. Any other column starts a new random-data-input sequence with a new column address. Every such sequence carries the destination row, so an empty patch list still retargets the page. After the cache load and after the program, the sequencer waits for the ready/busy line to fall and then rise again. It then reads the status byte and takes bit 0 as the fail indication.

A destination whose LUN or plane-select bits differ from the source is rejected at once, with no bus activity. The parameter SEL_MASK sets which row bits count as LUN/plane bits.

Top module: `nand_move_seq`

## Requirements
- R1: During and after reset, with no request, WE# and RE# are high, CLE, ALE, the data-output enable, done and the FIFO pop are all low.
- R2: A request first issues command 0x00, then five address bytes (column low, column high, both zero, then row bits 7:0, 15:8, 23:16 of the source row), then command 0x35.
- R3: Every patch sequence is command 0x85 followed by five address bytes: column bits 7:0, column bits 15:8, then the destination row bits 7:0, 15:8, 23:16.
- R4: At least TADL clock cycles pass between the rising WE# edge of the last address byte of a 0x85 sequence and the first data byte strobe.
- R5: Data bytes are driven one per WE# pulse and land at successive columns from the addressed column, so the committed page equals the source page with every patch applied in FIFO order.
- R6: A FIFO entry whose column equals the previous column plus one continues the current data phase; any other entry opens a new 0x85 sequence. The FIFO is popped only when not empty, and is drained by a successful move.
- R7: Command 0x10 follows the final data byte, no data byte follows it, and the page is committed at the destination row.
- R8: After 0x35 and after 0x10 the sequencer waits for RDY low and then high, issues status command 0x70, and strobes one read with RE#. After the program, err equals status bit 0.
- R9: If status bit 0 is set after the cache load, the request ends with err high and no 0x85 or 0x10 command is issued.
- R10: If (source XOR destination) AND SEL_MASK is nonzero, done and err go high on the cycle after start and no WE# strobe occurs.
- R11: With an empty patch FIFO, exactly one 0x85 sequence with column 0 and no data bytes is issued before 0x10.
- R12: CLE is high only in command cycles and ALE only in address cycles. The two are never high together, and each WE# low pulse lasts exactly TWP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken while idle |
| src_row | input | 24 | Source row address |
| dst_row | input | 24 | Destination row address |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Error result, valid with done |
| pf_empty | input | 1 | Patch FIFO empty |
| pf_col | input | 16 | Column of FIFO head entry |
| pf_data | input | 8 | Data byte of FIFO head entry |
| pf_rd | output | 1 | Pop the FIFO head |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto I/O[7:0] |
| nand_io_oe | output | 1 | Output enable for I/O[7:0] |
| nand_io_in | input | 8 | Byte read from I/O[7:0] |
| nand_rdy | input | 1 | Device ready/busy, high when ready |

## Verification
The bench targets the run-merging boundary: adjacent columns, repeated columns and a jump back to a lower column. A design that merged on the wrong condition would issue the wrong count of 0x85 sequences, or write bytes to shifted columns, and the committed page would differ from the bench's model. An empty patch list is tested on its own, because a sequencer that skipped the retarget would commit at the source row. A status fail after the cache load must stop before any program, or a program would still be issued. A LUN/plane mismatch must leave the bus untouched. The tADL gap is measured on every patch sequence, so a shortened hold-off shows up directly.

// File: rtl/nand_move_pkg.sv
package nand_move_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 24;
  localparam int NADDR  = 5;

  localparam logic [7:0] CMD_LOAD   = 8'h00;
  localparam logic [7:0] CMD_LOADGO = 8'h35;
  localparam logic [7:0] CMD_PATCH  = 8'h85;
  localparam logic [7:0] CMD_COMMIT = 8'h10;
  localparam logic [7:0] CMD_STATUS = 8'h70;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DATA, OP_READ} bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LCMD, ST_LADDR, ST_LGO, ST_BUSYLO, ST_BUSYHI, ST_STCMD,
    ST_STRD, ST_PCMD, ST_PADDR, ST_HOLD, ST_PDATA, ST_COMMIT, ST_DONE
  } seq_st_e;
endpackage

// File: rtl/nand_sel_match.sv
module nand_sel_match #(
  parameter int                 W    = 24,
  parameter logic [W-1:0]       MASK = '0
) (
  input  logic [W-1:0] row_a,
  input  logic [W-1:0] row_b,
  output logic         differ
);
  logic [W-1:0] diff_bits;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_chk
      assign diff_bits[i] = row_a[i] ^ row_b[i];
    end else begin : g_skip
      assign diff_bits[i] = 1'b0;
    end
  end

  assign differ = |diff_bits;
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe import nand_move_pkg::*; #(
  parameter int TWP = 3,
  parameter int TWH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_op_e    op,
  input  logic [7:0] wbyte,
  input  logic [7:0] io_in,
  output logic       we_n,
  output logic       re_n,
  output logic       cle,
  output logic       ale,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic [7:0] rbyte,
  output logic       done
);
  localparam int TMAX  = (TWP > TWH) ? TWP : TWH;
  localparam int CNT_W = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

  ph_e              ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  bus_op_e          op_q, op_n;
  logic [7:0]       byte_q, byte_n;
  logic [7:0]       rd_q, rd_n;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    op_n   = op_q;
    byte_n = byte_q;
    rd_n   = rd_q;
    unique case (ph_q)
      PH_IDLE: if (go) begin
        ph_n   = PH_LOW;
        cnt_n  = CNT_W'(TWP - 1);
        op_n   = op;
        byte_n = wbyte;
      end
      PH_LOW: if (cnt_q == '0) begin
        ph_n  = PH_HIGH;
        cnt_n = CNT_W'(TWH - 1);
        if (op_q == OP_READ) rd_n = io_in;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
      PH_HIGH: if (cnt_q == '0) ph_n = PH_IDLE;
               else cnt_n = cnt_q - 1'b1;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      byte_q <= byte_n;
      rd_q   <= rd_n;
    end
  end

  assign we_n   = !(ph_q == PH_LOW && op_q != OP_READ);
  assign re_n   = !(ph_q == PH_LOW && op_q == OP_READ);
  assign cle    = (ph_q != PH_IDLE) && (op_q == OP_CMD);
  assign ale    = (ph_q != PH_IDLE) && (op_q == OP_ADDR);
  assign io_oe  = (ph_q != PH_IDLE) && (op_q != OP_READ);
  assign io_out = byte_q;
  assign rbyte  = rd_q;
  assign done   = (ph_q == PH_HIGH) && (cnt_q == '0);

  // checker: length of the current WE# low run
  logic [7:0] we_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     we_low_run <= '0;
    else if (!we_n) we_low_run <= we_low_run + 1'b1;
    else            we_low_run <= '0;
  end

  a_r12_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && !$past(we_n)) |-> (we_low_run == 8'(TWP)));

  a_r12_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r8_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
endmodule

// File: rtl/nand_move_seq.sv
module nand_move_seq import nand_move_pkg::*; #(
  parameter int               TWP      = 3,
  parameter int               TWH      = 2,
  parameter int               TADL     = 14,
  parameter logic [ROW_W-1:0] SEL_MASK = 24'h010040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] src_row,
  input  logic [ROW_W-1:0] dst_row,
  output logic             done,
  output logic             err,
  input  logic             pf_empty,
  input  logic [COL_W-1:0] pf_col,
  input  logic [7:0]       pf_data,
  output logic             pf_rd,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rdy
);
  localparam int HOLD_W = $clog2(TADL + 2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  seq_st_e           st_q, st_n;
  logic              busy_q, busy_n;
  logic [2:0]        aidx_q, aidx_n;
  logic [HOLD_W-1:0] hold_q, hold_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [7:0]        dat_q, dat_n;
  logic              hasd_q, hasd_n;
  logic [ROW_W-1:0]  src_q, src_n, dst_q, dst_n;
  logic              prog_q, prog_n;
  logic              err_q, err_n;

  logic       go, bdone, sel_bad;
  bus_op_e    op;
  logic [7:0] obyte, rbyte;
  logic       st_unused;

  nand_sel_match #(.W(ROW_W), .MASK(SEL_MASK)) u_sel (
    .row_a(src_row), .row_b(dst_row), .differ(sel_bad));

  nand_strobe #(.TWP(TWP), .TWH(TWH)) u_strobe (
    .clk(clk), .rst_n(rst_s), .go(go), .op(op), .wbyte(obyte),
    .io_in(nand_io_in), .we_n(nand_we_n), .re_n(nand_re_n),
    .cle(nand_cle), .ale(nand_ale), .io_out(nand_io_out),
    .io_oe(nand_io_oe), .rbyte(rbyte), .done(bdone));

  assign st_unused = ^rbyte[7:1];

  function automatic logic [7:0] addr_byte(input logic [2:0] i,
                                           input logic [COL_W-1:0] c,
                                           input logic [ROW_W-1:0] r);
    case (i)
      3'd0:    return c[7:0];
      3'd1:    return c[15:8];
      3'd2:    return r[7:0];
      3'd3:    return r[15:8];
      default: return r[23:16];
    endcase
  endfunction

  logic is_bus, step;
  always_comb begin
    is_bus = 1'b1;
    op     = OP_CMD;
    obyte  = 8'h00;
    unique case (st_q)
      ST_LCMD:   obyte = CMD_LOAD;
      ST_LADDR:  begin op = OP_ADDR; obyte = addr_byte(aidx_q, '0, src_q); end
      ST_LGO:    obyte = CMD_LOADGO;
      ST_STCMD:  obyte = CMD_STATUS;
      ST_STRD:   op = OP_READ;
      ST_PCMD:   obyte = CMD_PATCH;
      ST_PADDR:  begin op = OP_ADDR; obyte = addr_byte(aidx_q, col_q, dst_q); end
      ST_PDATA:  begin op = OP_DATA; obyte = dat_q; end
      ST_COMMIT: obyte = CMD_COMMIT;
      default:   is_bus = 1'b0;
    endcase
    go   = is_bus && !busy_q;
    step = is_bus && busy_q && bdone;
  end

  always_comb begin
    st_n = st_q;   busy_n = busy_q; aidx_n = aidx_q; hold_n = hold_q;
    col_n = col_q; dat_n = dat_q;   hasd_n = hasd_q; src_n = src_q;
    dst_n = dst_q; prog_n = prog_q; err_n = err_q;   pf_rd = 1'b0;
    if (go)   busy_n = 1'b1;
    if (step) busy_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        src_n = src_row;
        dst_n = dst_row;
        err_n = sel_bad;
        st_n  = sel_bad ? ST_DONE : ST_LCMD;
      end
      ST_LCMD:  if (step) begin aidx_n = '0; st_n = ST_LADDR; end
      ST_LADDR: if (step) begin
        if (aidx_q == 3'(NADDR - 1)) st_n = ST_LGO;
        else aidx_n = aidx_q + 1'b1;
      end
      ST_LGO:    if (step) begin prog_n = 1'b0; st_n = ST_BUSYLO; end
      ST_BUSYLO: if (!nand_rdy) st_n = ST_BUSYHI;
      ST_BUSYHI: if (nand_rdy)  st_n = ST_STCMD;
      ST_STCMD:  if (step) st_n = ST_STRD;
      ST_STRD: if (step) begin
        if (prog_q || rbyte[0]) begin
          err_n = rbyte[0];
          st_n  = ST_DONE;
        end else begin
          st_n   = ST_PCMD;
          hasd_n = !pf_empty;
          pf_rd  = !pf_empty;
          col_n  = pf_empty ? '0 : pf_col;
          dat_n  = pf_data;
        end
      end
      ST_PCMD:  if (step) begin aidx_n = '0; st_n = ST_PADDR; end
      ST_PADDR: if (step) begin
        if (aidx_q == 3'(NADDR - 1)) begin
          hold_n = HOLD_W'(TADL);
          st_n   = ST_HOLD;
        end else aidx_n = aidx_q + 1'b1;
      end
      ST_HOLD:
        if (hold_q == '0) st_n = hasd_q ? ST_PDATA : ST_COMMIT;
        else hold_n = hold_q - 1'b1;
      ST_PDATA: if (step) begin
        if (!pf_empty) begin
          pf_rd = 1'b1;
          col_n = pf_col;
          dat_n = pf_data;
          if (pf_col != col_q + 16'd1) st_n = ST_PCMD;
        end else st_n = ST_COMMIT;
      end
      ST_COMMIT: if (step) begin prog_n = 1'b1; st_n = ST_BUSYLO; end
      ST_DONE:   st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; busy_q <= 1'b0; aidx_q <= '0; hold_q <= '0;
      col_q <= '0; dat_q <= '0; hasd_q <= 1'b0; src_q <= '0; dst_q <= '0;
      prog_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; busy_q <= busy_n; aidx_q <= aidx_n; hold_q <= hold_n;
      col_q <= col_n; dat_q <= dat_n; hasd_q <= hasd_n; src_q <= src_n;
      dst_q <= dst_n; prog_q <= prog_n; err_q <= err_n;
    end
  end

  assign done = (st_q == ST_DONE);
  assign err  = err_q;

  a_r10_sel_abort: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE && start && sel_bad) |=> (done && err));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_s)
    pf_rd |-> !pf_empty);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE) |-> (nand_we_n && nand_re_n && !pf_rd));
endmodule

// File: tb/nand_move_seq_tb.sv
`timescale 1ns/1ps
module nand_move_seq_tb;
  localparam int          TWP  = 3;
  localparam int          TWH  = 2;
  localparam int          TADL = 14;
  localparam logic [23:0] MASK = 24'h010040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start;
  logic [23:0] src_row, dst_row;
  logic        done, err, pf_empty, pf_rd;
  logic [15:0] pf_col;
  logic [7:0]  pf_data, io_out, io_in;
  logic        cle, ale, we_n, re_n, io_oe, rdy;

  nand_move_seq #(.TWP(TWP), .TWH(TWH), .TADL(TADL), .SEL_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_row(src_row),
    .dst_row(dst_row), .done(done), .err(err), .pf_empty(pf_empty),
    .pf_col(pf_col), .pf_data(pf_data), .pf_rd(pf_rd), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in),
    .nand_rdy(rdy));

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // patch FIFO
  logic [15:0] qcol [64];
  logic [7:0]  qdat [64];
  int qhead = 0, qtail = 0;
  assign pf_empty = (qhead == qtail);
  assign pf_col   = qcol[qhead[5:0]];
  assign pf_data  = qdat[qhead[5:0]];
  always @(posedge clk) if (pf_rd) qhead <= qhead + 1;

  function automatic logic [7:0] src_byte(input logic [23:0] r, input int c);
    return r[7:0] ^ r[15:8] ^ 8'(c * 7) ^ 8'h5A;
  endfunction

  // device model, sampled on the falling edge
  logic [7:0]  cache [256];
  logic [7:0]  abuf [5];
  int          acnt, cyc, last_addr_cyc, min_gap, n85, n10, n70, ndata, nwe;
  int          viol, bad_order, bad_row, we_low, busy_pre, busy_len;
  logic [7:0]  last_cmd, first_cmd;
  logic [23:0] rd_row, prog_row, tgt_row, exp_dst;
  logic [15:0] rd_col, col_ptr;
  logic        prev_we, first_pend, post10, inj_rd, inj_pg, fail_now, any_cmd;

  assign io_in = {1'b1, 6'b0, fail_now};

  always @(negedge clk) begin
    cyc++;
    if (cle && ale) viol++;
    if (!we_n && !re_n) viol++;
    if (!we_n) we_low++;
    if (busy_pre > 0) begin
      busy_pre--;
      if (busy_pre == 0) begin rdy = 1'b0; busy_len = 8; end
    end else if (busy_len > 0) begin
      busy_len--;
      if (busy_len == 0) rdy = 1'b1;
    end
    if (!prev_we && we_n) begin
      nwe++;
      if (we_low != TWP) viol++;
      if (cle) begin
        if (!any_cmd) first_cmd = io_out;
        any_cmd = 1'b1;
        last_cmd = io_out;
        case (io_out)
          8'h00: acnt = 0;
          8'h35: begin
            rd_row = {abuf[4], abuf[3], abuf[2]};
            rd_col = {abuf[1], abuf[0]};
            for (int c = 0; c < 256; c++) cache[c] = src_byte(rd_row, c);
            busy_pre = 3; fail_now = inj_rd;
          end
          8'h85: begin acnt = 0; n85++; first_pend = 1'b1; end
          8'h10: begin
            n10++; prog_row = tgt_row; post10 = 1'b1;
            busy_pre = 3; fail_now = inj_pg;
          end
          8'h70: n70++;
          default: viol++;
        endcase
      end else if (ale) begin
        if (acnt < 5) abuf[acnt] = io_out;
        acnt++;
        if (acnt == 5 && last_cmd == 8'h85) begin
          col_ptr = {abuf[1], abuf[0]};
          tgt_row = {abuf[4], abuf[3], abuf[2]};
          if (tgt_row != exp_dst) bad_row++;
          last_addr_cyc = cyc;
        end
      end else begin
        if (post10) bad_order++;
        if (first_pend) begin
          if (cyc - last_addr_cyc < min_gap) min_gap = cyc - last_addr_cyc;
          first_pend = 1'b0;
        end
        cache[col_ptr[7:0]] = io_out;
        col_ptr++;
        ndata++;
      end
    end
    if (we_n) we_low = 0;
    prev_we = we_n;
  end

  task automatic model_clear();
    acnt = 0; n85 = 0; n10 = 0; n70 = 0; ndata = 0; nwe = 0; viol = 0;
    bad_order = 0; bad_row = 0; min_gap = 1 << 30; first_pend = 1'b0;
    post10 = 1'b0; any_cmd = 1'b0; first_cmd = 8'hFF; last_cmd = 8'hFF;
    rd_row = '1; rd_col = '1; prog_row = '1; tgt_row = '1; fail_now = 1'b0;
  endtask

  logic [15:0] pcol [64];
  logic [7:0]  pdat [64];
  bit hung = 1'b0;

  task automatic run_move(input logic [23:0] src, input logic [23:0] dst,
                          input int n, input bit frd, input bit fpg);
    logic [7:0] expc [256];
    int runs, miss, wd;
    bit sel_bad, eerr;
    if (hung) return;
    @(posedge clk); #1;
    model_clear();
    inj_rd = frd; inj_pg = fpg; exp_dst = dst;
    qhead = 0;
    for (int i = 0; i < n; i++) begin qcol[i] = pcol[i]; qdat[i] = pdat[i]; end
    qtail = n;
    src_row = src; dst_row = dst; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wd = 0;
    @(negedge clk);
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    if (!done) begin
      hung = 1'b1;
      check(1'b0, "watchdog", wd, 0);
      return;
    end
    sel_bad = |((src ^ dst) & MASK);
    eerr    = sel_bad || frd || fpg;
    check(err == eerr, "R8/R9/R10 err flag", err, eerr);
    check(viol == 0, "R12 strobe/latch rules", viol, 0);
    if (sel_bad) begin
      check(nwe == 0, "R10 no bus activity", nwe, 0);
      return;
    end
    check(first_cmd == 8'h00, "R2 first command", first_cmd, 0);
    check(rd_row == src && rd_col == 0, "R2 load address", rd_row, src);
    if (frd) begin
      check(n85 == 0 && n10 == 0, "R9 no patch or program", n85 + n10, 0);
      check(n70 == 1, "R9 one status read", n70, 1);
      return;
    end
    runs = (n == 0) ? 1 : 0;
    for (int i = 0; i < n; i++)
      if (i == 0 || pcol[i] != pcol[i-1] + 16'd1) runs++;
    for (int c = 0; c < 256; c++) expc[c] = src_byte(src, c);
    for (int i = 0; i < n; i++) expc[pcol[i][7:0]] = pdat[i];
    miss = 0;
    for (int c = 0; c < 256; c++) if (cache[c] !== expc[c]) miss++;
    check(n85 == runs, "R6 patch sequence count", n85, runs);
    check(bad_row == 0, "R3 destination row in 0x85", bad_row, 0);
    check(ndata == n, "R5 data byte count", ndata, n);
    check(miss == 0, "R5 committed page contents", miss, 0);
    check(prog_row == dst, "R7 commit row", prog_row, dst);
    check(n10 == 1 && bad_order == 0, "R7 commit after data", n10 * 10 + bad_order, 10);
    check(n70 == 2, "R8 status after busy", n70, 2);
    check(qhead == qtail, "R6 FIFO drained", qhead, qtail);
    if (n > 0) check(min_gap >= TADL, "R4 address-to-data hold", min_gap, TADL);
    else check(n85 == 1 && ndata == 0, "R11 empty list retarget", n85 * 10 + ndata, 10);
  endtask

  initial begin
    int seed, n, pc;
    logic [23:0] s, d;
    seed = 31337;
    void'($urandom(seed));
    rst_n = 1'b0; start = 1'b0; src_row = '0; dst_row = '0;
    rdy = 1'b1; prev_we = 1'b1; we_low = 0; busy_pre = 0; busy_len = 0;
    inj_rd = 1'b0; inj_pg = 1'b0; exp_dst = '0; cyc = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(we_n && re_n && !cle && !ale && !io_oe && !done && !pf_rd,
          "R1 reset outputs", {we_n, re_n, cle, ale, io_oe, done, pf_rd}, 7'b1100000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(we_n && re_n && !cle && !ale && !io_oe && !done && !pf_rd,
          "R1 idle after reset", {we_n, re_n, cle, ale, io_oe, done, pf_rd}, 7'b1100000);

    // R11: empty patch list
    run_move(24'h12_3456, 24'h12_1456, 0, 1'b0, 1'b0);
    // R6: contiguous run, a jump, then a repeated column
    pcol[0] = 16'd10; pdat[0] = 8'hA0;
    pcol[1] = 16'd11; pdat[1] = 8'hA1;
    pcol[2] = 16'd12; pdat[2] = 8'hA2;
    pcol[3] = 16'd200; pdat[3] = 8'hB0;
    pcol[4] = 16'd200; pdat[4] = 8'hB1;
    pcol[5] = 16'd3;  pdat[5] = 8'hC0;
    run_move(24'h00_0081, 24'h00_7F81, 6, 1'b0, 1'b0);
    // R10: plane bit differs
    run_move(24'h00_1000, 24'h00_1040, 2, 1'b0, 1'b0);
    // R10: LUN bit differs
    run_move(24'h00_1000, 24'h01_1000, 0, 1'b0, 1'b0);
    // R9: fail after the load
    run_move(24'h00_2200, 24'h00_2300, 2, 1'b1, 1'b0);
    // R8: fail after the program
    pcol[0] = 16'd255; pdat[0] = 8'h55;
    run_move(24'h00_3300, 24'h00_3400, 1, 1'b0, 1'b1);

    for (int t = 0; t < 20; t++) begin
      n = $urandom_range(0, 6);
      pc = $urandom_range(0, 250);
      for (int i = 0; i < n; i++) begin
        if (i > 0 && $urandom_range(0, 1) == 1 && pc < 254) pc = pc + 1;
        else if (i > 0) pc = $urandom_range(0, 250);
        pcol[i] = 16'(pc);
        pdat[i] = 8'($urandom);
      end
      s = 24'($urandom);
      d = (24'($urandom) & ~MASK) | (s & MASK);
      if ($urandom_range(0, 7) == 0) d = d ^ MASK;
      run_move(s, d, n, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule